// File: doc/BRIEF.md
# Interrupt Bus Short-Message Transmitter

This block sends one short interrupt message over a two-lane, wired-OR style interrupt bus. A request carries a 4-bit sender ID, a destination-mode flag, a 3-bit delivery mode, level and trigger flags, an 8-bit vector and an 8-bit destination. The block latches the request and then steps through a fixed 21-cycle frame. The frame has a start cycle, four arbitration cycles, eleven payload cycles, a checksum cycle and a postamble. Two status cycles and an idle cycle close the frame.

The electrical bus is modelled as two signals. `bus_drv` is what this agent asserts, where 1 means dominant. `bus_in` is the resolved bus value, sampled at every rising edge. When the message fails, the block resends it without outside help, starting again from the start cycle. It stops resending only when the message is accepted. When another agent wins arbitration, the block goes silent until the frame ends and then tries again.

Top module: `intbus_short_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `bus_drv` is 00, `done` is 0 and `busy` is 0. A `req_valid` pulse while idle raises `busy`, and frame cycle 1 is driven in the next clock cycle.
- R2: Frame cycle 1 (start) drives 01, with bit 0 being lane 0.
- R3: Cycles 2 to 5 drive the ID on lane 0, most significant bit first. Lane 1 is 0 in these cycles.
- R4: Payload pairs are written {lane1, lane0}, as follows:
  - cycle 6 is {dest mode, mode[2]};
  - cycle 7 is mode[1:0];
  - cycle 8 is {level, trigger};
  - cycles 9 to 12 carry the vector, most significant pair first.
- R5: In logical destination mode (flag = 1), cycles 13 to 16 carry the destination, most significant pair first. In physical mode, cycles 13 and 14 are 00, cycle 15 is ID[3:2] and cycle 16 is ID[1:0].
- R6: Cycle 17 carries the low two bits of a 3-bit running sum. The sum starts at zero. In each of cycles 6 to 16 it becomes: its low two bits, plus that cycle's pair, plus its old bit 2.
- R7: Cycles 18 to 21 drive 00.
- R8: In cycles 2 to 5, if `bus_in[0]` differs from the driven lane-0 bit, the agent has lost arbitration. It then drives 00 up to cycle 21, raises no `done`, and restarts at cycle 1 in the next cycle.
- R9: Status is decided from the two status cycles, in this order:
  - a `bus_in` of 11 in cycle 19 gives status 11 (checksum error);
  - otherwise, 11 in cycle 20 gives 01 (accepted);
  - otherwise the status is 10 (retry).
- R10: `done` is a one-cycle pulse in the cycle after frame cycle 21, carrying the status. After status 01, `busy` falls in that same cycle. After status 10 or 11, the frame restarts at cycle 1 in that same cycle.
- R11: A `req_valid` that arrives while `busy` is high has no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_id | input | 4 | Sender ID used for arbitration |
| req_logical | input | 1 | Destination mode: 1 logical, 0 physical |
| req_mode | input | 3 | Delivery mode |
| req_level | input | 1 | Level flag |
| req_trig | input | 1 | Trigger-mode flag |
| req_vector | input | 8 | Interrupt vector |
| req_dest | input | 8 | Logical destination |
| busy | output | 1 | A message is pending |
| bus_drv | output | 2 | Lanes asserted by this agent (1 = dominant) |
| bus_in | input | 2 | Resolved bus value |
| done | output | 1 | One-cycle end-of-message pulse |
| status | output | 2 | 01 accepted, 10 retry, 11 checksum error |

## Verification
The hardest case to reach is a loss of arbitration in the last arbitration cycle, followed by a silent frame and then a clean restart. The bench reaches it by choosing an ID whose low bit is 0 and asserting lane 0 from a model agent in exactly cycle 5. It then checks that the same message is sent again in full. Chained failures are reached the same way, by driving the status lanes from the bench: a checksum error, then a retry, then acceptance. A sweep over every ID, both destination modes and every delivery mode compares each frame cycle with a frame and checksum computed in the bench.

// File: rtl/intbus_short_tx.sv
module intbus_short_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_id,
  input  logic       req_logical,
  input  logic [2:0] req_mode,
  input  logic       req_level,
  input  logic       req_trig,
  input  logic [7:0] req_vector,
  input  logic [7:0] req_dest,
  output logic       busy,
  output logic [1:0] bus_drv,
  input  logic [1:0] bus_in,
  output logic       done,
  output logic [1:0] status
);
  localparam logic [4:0] C_START = 5'd1;
  localparam logic [4:0] C_ARB_LO = 5'd2;
  localparam logic [4:0] C_ARB_HI = 5'd5;
  localparam logic [4:0] C_PAY_LO = 5'd6;
  localparam logic [4:0] C_PAY_HI = 5'd16;
  localparam logic [4:0] C_ST0 = 5'd19;
  localparam logic [4:0] C_ST1 = 5'd20;
  localparam logic [4:0] C_LAST = 5'd21;
  localparam logic [1:0] ST_ACC = 2'b01;
  localparam logic [1:0] ST_RETRY = 2'b10;
  localparam logic [1:0] ST_CSERR = 2'b11;

  logic [4:0] cyc;
  logic       lost;
  logic [2:0] cs;
  logic [1:0] s0_q, code_q, pair;
  logic [3:0] id_q;
  logic       log_q, lvl_q, trg_q;
  logic [2:0] mode_q;
  logic [7:0] vec_q, dst_q;

  wire in_arb = busy && cyc >= C_ARB_LO && cyc <= C_ARB_HI;
  wire in_pay = busy && cyc >= C_PAY_LO && cyc <= C_PAY_HI;

  always_comb begin
    pair = 2'b00;
    case (cyc)
      5'd1:  pair = 2'b01;
      5'd2:  pair = {1'b0, id_q[3]};
      5'd3:  pair = {1'b0, id_q[2]};
      5'd4:  pair = {1'b0, id_q[1]};
      5'd5:  pair = {1'b0, id_q[0]};
      5'd6:  pair = {log_q, mode_q[2]};
      5'd7:  pair = mode_q[1:0];
      5'd8:  pair = {lvl_q, trg_q};
      5'd9:  pair = vec_q[7:6];
      5'd10: pair = vec_q[5:4];
      5'd11: pair = vec_q[3:2];
      5'd12: pair = vec_q[1:0];
      5'd13: pair = log_q ? dst_q[7:6] : 2'b00;
      5'd14: pair = log_q ? dst_q[5:4] : 2'b00;
      5'd15: pair = log_q ? dst_q[3:2] : id_q[3:2];
      5'd16: pair = log_q ? dst_q[1:0] : id_q[1:0];
      5'd17: pair = cs[1:0];
      default: pair = 2'b00;
    endcase
  end

  assign bus_drv = (busy && !lost) ? pair : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cyc <= '0; lost <= 1'b0; cs <= '0;
      s0_q <= '0; code_q <= '0; done <= 1'b0; status <= '0;
      id_q <= '0; log_q <= 1'b0; mode_q <= '0; lvl_q <= 1'b0;
      trg_q <= 1'b0; vec_q <= '0; dst_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1; cyc <= C_START;
          id_q <= req_id; log_q <= req_logical; mode_q <= req_mode;
          lvl_q <= req_level; trg_q <= req_trig;
          vec_q <= req_vector; dst_q <= req_dest;
        end
      end else begin
        if (cyc == C_START) cs <= '0;
        if (in_pay) cs <= {1'b0, cs[1:0]} + {1'b0, pair} + {2'b00, cs[2]};
        if (in_arb && !lost && bus_in[0] != pair[0]) lost <= 1'b1;
        if (cyc == C_ST0) s0_q <= bus_in;
        if (cyc == C_ST1)
          code_q <= (s0_q == 2'b11) ? ST_CSERR : (bus_in == 2'b11) ? ST_ACC : ST_RETRY;
        if (cyc == C_LAST) begin
          if (lost) begin
            lost <= 1'b0;
            cyc <= C_START;
          end else begin
            done <= 1'b1;
            status <= code_q;
            if (code_q == ST_ACC) begin
              busy <= 1'b0;
              cyc <= '0;
            end else begin
              cyc <= C_START;
            end
          end
        end else begin
          cyc <= cyc + 5'd1;
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_drv == 2'b00);
  p_arb_lane1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_arb |-> bus_drv[1] == 1'b0);
  p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc > 5'd17) |-> bus_drv == 2'b00);
  p_lost_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_arb && bus_in[0] != bus_drv[0]) |=> bus_drv == 2'b00);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b00);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != ST_ACC) |-> (busy && cyc == C_START));
endmodule

// File: tb/intbus_short_tx_tb_top.sv
module intbus_short_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_logical = 1'b0, req_level = 1'b0, req_trig = 1'b0;
  logic [3:0] req_id = '0;
  logic [2:0] req_mode = '0;
  logic [7:0] req_vector = '0, req_dest = '0;
  logic busy, done;
  logic [1:0] bus_drv, status, other = 2'b00;
  wire  [1:0] bus_in = bus_drv | other;

  int checks = 0, errors = 0;
  logic [3:0] f_id; logic f_log, f_lvl, f_trg; logic [2:0] f_mode; logic [7:0] f_vec, f_dst;
  bit noise = 0;

  always #4 clk = ~clk;

  intbus_short_tx dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_logical(req_logical), .req_mode(req_mode), .req_level(req_level), .req_trig(req_trig),
    .req_vector(req_vector), .req_dest(req_dest), .busy(busy), .bus_drv(bus_drv),
    .bus_in(bus_in), .done(done), .status(status));

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pair(int k, logic [2:0] cs);
    case (k)
      1: return 2'b01;
      2: return {1'b0, f_id[3]};
      3: return {1'b0, f_id[2]};
      4: return {1'b0, f_id[1]};
      5: return {1'b0, f_id[0]};
      6: return {f_log, f_mode[2]};
      7: return f_mode[1:0];
      8: return {f_lvl, f_trg};
      9, 10, 11, 12: return 2'((f_vec >> (2 * (12 - k))) & 8'h3);
      13, 14, 15, 16: return f_log ? 2'((f_dst >> (2 * (16 - k))) & 8'h3)
                                   : (k == 15 ? f_id[3:2] : (k == 16 ? f_id[1:0] : 2'b00));
      17: return cs[1:0];
      default: return 2'b00;
    endcase
  endfunction

  task automatic start_req();
    @(negedge clk);
    req_valid = 1'b1; req_id = f_id; req_logical = f_log; req_mode = f_mode;
    req_level = f_lvl; req_trig = f_trg; req_vector = f_vec; req_dest = f_dst;
  endtask

  task automatic frame(input logic [1:0] st19, input logic [1:0] st20, input int clash_k,
                       input bit exp_done, input logic [1:0] exp_code);
    logic [2:0] cs = '0;
    for (int k = 1; k <= 21; k++) begin
      logic [1:0] e;
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        chk(done == exp_done, "R10 done at restart", 8'(done), 8'(exp_done));
        if (exp_done) chk(status == exp_code, "R9 status code", 8'(status), 8'(exp_code));
        chk(busy == 1'b1, "R1 busy during frame", 8'(busy), 8'd1);
      end
      if (noise && k == 10) begin
        req_valid = 1'b1; req_id = ~f_id; req_vector = ~f_vec; req_dest = ~f_dst; req_logical = ~f_log;
      end
      if (noise && k == 11) req_valid = 1'b0;
      e = exp_pair(k, cs);
      if (clash_k > 0 && k > clash_k) e = 2'b00;
      if (k >= 6 && k <= 16) cs = 3'({1'b0, cs[1:0]} + {1'b0, e} + {2'b00, cs[2]});
      if (k == 1) chk(bus_drv == e, "R2 start pair", 8'(bus_drv), 8'(e));
      else if (k <= 5) chk(bus_drv == e, clash_k > 0 ? "R8 arbitration drive" : "R3 arbitration bit", 8'(bus_drv), 8'(e));
      else if (k <= 12) chk(bus_drv == e, clash_k > 0 ? "R8 silent after loss" : (noise ? "R11 frame unchanged" : "R4 payload pair"), 8'(bus_drv), 8'(e));
      else if (k <= 16) chk(bus_drv == e, clash_k > 0 ? "R8 silent after loss" : "R5 destination pair", 8'(bus_drv), 8'(e));
      else if (k == 17) chk(bus_drv == e, clash_k > 0 ? "R8 silent after loss" : "R6 checksum pair", 8'(bus_drv), 8'(e));
      else chk(bus_drv == e, "R7 tail zero", 8'(bus_drv), 8'(e));
      other = (k == clash_k) ? 2'b01 : (k == 19) ? st19 : (k == 20) ? st20 : 2'b00;
    end
    @(posedge clk);
    other = 2'b00;
  endtask

  task automatic end_accept();
    @(negedge clk);
    chk(done == 1'b1, "R10 done pulse", 8'(done), 8'd1);
    chk(status == 2'b01, "R9 accepted code", 8'(status), 8'd1);
    chk(busy == 1'b0, "R10 busy cleared", 8'(busy), 8'd0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 8'(done), 8'd0);
    chk(bus_drv == 2'b00, "R1 idle quiet", 8'(bus_drv), 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && bus_drv == 0, "R1 reset state", {5'd0, busy, done, |bus_drv}, 8'd0);
    rst_n = 1'b1;
    for (int id = 0; id < 16; id++)
      for (int dm = 0; dm < 2; dm++)
        for (int md = 0; md < 8; md++) begin
          f_id = 4'(id); f_log = dm[0]; f_mode = 3'(md);
          f_lvl = md[0]; f_trg = id[0] ^ md[1];
          f_vec = 8'(id * 16 + md * 2 + dm) ^ 8'hA5;
          f_dst = 8'(id * 7 + md * 29 + dm * 100);
          start_req();
          frame(2'b00, 2'b11, 0, 1'b0, 2'b00);
          end_accept();
        end
    f_id = 4'b1011; f_log = 1; f_mode = 3'd5; f_lvl = 1; f_trg = 0; f_vec = 8'hFF; f_dst = 8'hFF;
    start_req();
    frame(2'b11, 2'b00, 0, 1'b0, 2'b00);
    frame(2'b01, 2'b10, 0, 1'b1, 2'b11);
    frame(2'b00, 2'b11, 0, 1'b1, 2'b10);
    end_accept();
    f_id = 4'b1110; f_log = 0; f_mode = 3'd1; f_vec = 8'h3C; f_dst = 8'h00;
    start_req();
    frame(2'b00, 2'b00, 5, 1'b0, 2'b00);
    frame(2'b00, 2'b11, 0, 1'b0, 2'b00);
    end_accept();
    f_id = 4'b0101; f_log = 1; f_vec = 8'h81; f_dst = 8'h42;
    start_req();
    frame(2'b00, 2'b00, 2, 1'b0, 2'b00);
    frame(2'b00, 2'b11, 0, 1'b0, 2'b00);
    end_accept();
    noise = 1;
    f_id = 4'b0011; f_log = 0; f_mode = 3'd7; f_vec = 8'h5A; f_dst = 8'hC3;
    start_req();
    frame(2'b00, 2'b11, 0, 1'b0, 2'b00);
    end_accept();
    noise = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && bus_drv == 0, "R11 no late start", {6'd0, busy, |bus_drv}, 8'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule